// File: doc/BRIEF.md
# Receive Clock Source Lock Controller

This block picks the timing source that the receive clock recovery loop should follow. It either tracks the incoming serial data or falls back to the local reference clock. Two checks feed the choice. The first is a frequency check. Over a window of a fixed number of reference word ticks, the block counts the words it received and compares the difference with two thresholds given in parts per million. The stricter threshold applies while the block is out of lock and the looser one applies while it is in lock, which gives hysteresis. The second check is a loss-of-signal detector. It trips when a run of received parallel words holds nothing but ones, or nothing but zeros, for too long.

Both ticks are single-cycle pulses in one sampling clock domain: one pulse per reference word period and one per recovered word. A request to move onto the data source takes effect only at the end of a measurement window. Moving back to the reference happens at once, on loss of signal or when the active-low force input is low. With the default thresholds of 244 and 488 ppm, data up to 400 ppm away from the reference holds lock, but cannot win lock back after a loss. The 12-word run limit means that 119 identical bits in a row never trip the detector and 129 always do.

Top module: `rxsrc_lock_ctrl`

## Requirements
- R1: After reset, lock_data, freq_ok and sig_lost are all 0.
- R2: A measurement window closes on the 2^WIN_LOG2-th ref_tick since the last close, or since reset. The offset is the number of word_valid cycles in the window, counting the closing cycle, minus 2^WIN_LOG2.
- R3: While freq_ok is 0, it becomes 1 in the cycle after a window closes only when |offset| <= floor(2^WIN_LOG2 * LOCK_PPM / 10^6). Otherwise it stays 0.
- R4: While freq_ok is 1, it stays 1 at a window close when |offset| <= floor(2^WIN_LOG2 * UNLOCK_PPM / 10^6), and drops to 0 when |offset| exceeds that value. freq_ok never changes except in the cycle after a window close.
- R5: A word is uniform when all of its WORD_W bits are 0, or all are 1. sig_lost is 1 in the cycle after the RUN_WORDS-th consecutive valid uniform word of the same polarity. With fewer such words, sig_lost stays 0.
- R6: A valid mixed word clears the run, so sig_lost is 0 in the next cycle. A valid uniform word of the opposite polarity restarts the run at one word. Cycles with word_valid low leave the run unchanged.
- R7: lock_data rises only in the cycle after a window close. It rises only when the new freq_ok is 1, sig_lost is 0 and force_ref_n is 1.
- R8: lock_data is 0 in the cycle after any cycle in which force_ref_n is 0. It is 0 whenever sig_lost is 1. It drops at a window close whose frequency test fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both tick streams |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| ref_tick | input | 1 | One pulse per reference word period |
| word_valid | input | 1 | One pulse per recovered word; qualifies word |
| word | input | WORD_W | Received parallel word |
| force_ref_n | input | 1 | Active low; forces the reference as the clock source |
| lock_data | output | 1 | 1 = track incoming data, 0 = track reference |
| freq_ok | output | 1 | Frequency test state with hysteresis |
| sig_lost | output | 1 | Run-length loss-of-signal flag |

## Verification
A wrong window count shows first on freq_ok, which changes one window early or late. That error can stay hidden for a whole window, so every window's close cycle is compared. A threshold register picked from the wrong hysteresis state only shows when the offset lies between the two limits, so the offsets are placed there on purpose from both directions. A faulty run counter shows on sig_lost within a word of the 11th or 12th uniform word. It also shows when a polarity change or a gap in word_valid falls inside a run.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;

  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } clk_src_e;

  // floor(window * ppm / 1e6), computed at elaboration time
  function automatic int ppm_to_count(input int win_log2, input int ppm);
    longint w;
    w = longint'(1) << win_log2;
    return int'((w * longint'(ppm)) / 64'd1000000);
  endfunction

endpackage

// File: rtl/freq_meter.sv
module freq_meter
  import lockctl_pkg::*;
#(
  parameter int WIN_LOG2   = 15,
  parameter int LOCK_PPM   = 244,
  parameter int UNLOCK_PPM = 488
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic rec_tick,
  output logic win_end,
  output logic pass_nxt,
  output logic freq_ok
);

  localparam int WIN    = 1 << WIN_LOG2;
  localparam int CW     = WIN_LOG2 + 2;
  localparam int LOCK_TH   = ppm_to_count(WIN_LOG2, LOCK_PPM);
  localparam int UNLOCK_TH = ppm_to_count(WIN_LOG2, UNLOCK_PPM);
  localparam logic [CW-1:0] REC_MAX = {CW{1'b1}};
  localparam logic [CW:0]   WIN_EXT = (CW+1)'(WIN);
  localparam logic [CW:0]   LOCK_LIM   = (CW+1)'(LOCK_TH);
  localparam logic [CW:0]   UNLOCK_LIM = (CW+1)'(UNLOCK_TH);

  logic [WIN_LOG2-1:0] ref_cnt, ref_cnt_nxt;
  logic [CW-1:0]       rec_cnt, rec_cnt_nxt, rec_sum;
  logic [CW:0]         diff, mag;
  logic                freq_ok_nxt;
  logic                win_last;

  assign win_last = (ref_cnt == {WIN_LOG2{1'b1}});
  assign win_end  = ref_tick && win_last;

  always_comb begin
    if (rec_tick && (rec_cnt != REC_MAX)) rec_sum = rec_cnt + 1'b1;
    else                                  rec_sum = rec_cnt;
    diff = {1'b0, rec_sum} - WIN_EXT;
    mag  = diff[CW] ? (~diff + 1'b1) : diff;
    if (freq_ok) pass_nxt = (mag <= UNLOCK_LIM);
    else         pass_nxt = (mag <= LOCK_LIM);
  end

  always_comb begin
    ref_cnt_nxt = ref_cnt;
    rec_cnt_nxt = rec_sum;
    freq_ok_nxt = freq_ok;
    if (win_end) begin
      ref_cnt_nxt = '0;
      rec_cnt_nxt = '0;
      freq_ok_nxt = pass_nxt;
    end else if (ref_tick) begin
      ref_cnt_nxt = ref_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      rec_cnt <= '0;
      freq_ok <= 1'b0;
    end else begin
      ref_cnt <= ref_cnt_nxt;
      rec_cnt <= rec_cnt_nxt;
      freq_ok <= freq_ok_nxt;
    end
  end

  // R4: the frequency flag moves only right after a window close
  a_r4_change_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_ok) |-> $past(win_end));

  // R3: a window close with a small offset from the unlocked state must lock
  a_r3_lock_small_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !freq_ok && (mag == '0)) |=> freq_ok);

endmodule

// File: rtl/run_detector.sv
module run_detector #(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              los_nxt,
  output logic              los
);

  localparam int NW = $clog2(RUN_WORDS + 1);
  localparam logic [NW-1:0] LIMIT = NW'(RUN_WORDS);

  logic [NW-1:0] run_cnt, run_cnt_nxt;
  logic          run_pol, run_pol_nxt;
  logic          all_zero, all_one, mixed;

  assign all_zero = (word == '0);
  assign all_one  = (word == '1);
  assign mixed    = !all_zero && !all_one;

  always_comb begin
    run_cnt_nxt = run_cnt;
    run_pol_nxt = run_pol;
    if (word_valid) begin
      if (mixed) begin
        run_cnt_nxt = '0;
      end else if ((run_cnt != '0) && (run_pol == all_one)) begin
        if (run_cnt != LIMIT) run_cnt_nxt = run_cnt + 1'b1;
      end else begin
        run_cnt_nxt = NW'(1);
        run_pol_nxt = all_one;
      end
    end
    los_nxt = (run_cnt_nxt == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_pol <= 1'b0;
      los     <= 1'b0;
    end else begin
      run_cnt <= run_cnt_nxt;
      run_pol <= run_pol_nxt;
      los     <= los_nxt;
    end
  end

  // R5: the run counter saturates at the limit
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);

  // R6: a valid mixed word always clears loss of signal
  a_r6_mixed_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && mixed) |=> !los);

  // R6: cycles without a valid word leave the run untouched
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(run_cnt));

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lockctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic force_ref_n,
  input  logic los_nxt,
  input  logic win_end,
  input  logic pass_nxt,
  output logic lock_data
);

  clk_src_e src, src_nxt;

  always_comb begin
    src_nxt = src;
    if (!force_ref_n || los_nxt) src_nxt = SRC_REF;
    else if (win_end)            src_nxt = pass_nxt ? SRC_DATA : SRC_REF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src <= SRC_REF;
    else        src <= src_nxt;
  end

  assign lock_data = (src == SRC_DATA);

  // R8: forcing the reference wins in the next cycle
  a_r8_force_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !force_ref_n |=> !lock_data);

  // R7: the data source is entered only at a passing window close
  a_r7_rise_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_data) |-> $past(win_end && pass_nxt && force_ref_n));

endmodule

// File: rtl/rxsrc_lock_ctrl.sv
module rxsrc_lock_ctrl
  import lockctl_pkg::*;
#(
  parameter int WIN_LOG2   = 15,
  parameter int LOCK_PPM   = 244,
  parameter int UNLOCK_PPM = 488,
  parameter int WORD_W     = 10,
  parameter int RUN_WORDS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  input  logic              force_ref_n,
  output logic              lock_data,
  output logic              freq_ok,
  output logic              sig_lost
);

  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       win_end, pass_nxt, los_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  freq_meter #(
    .WIN_LOG2  (WIN_LOG2),
    .LOCK_PPM  (LOCK_PPM),
    .UNLOCK_PPM(UNLOCK_PPM)
  ) u_freq (
    .clk     (clk),
    .rst_n   (rst_q),
    .ref_tick(ref_tick),
    .rec_tick(word_valid),
    .win_end (win_end),
    .pass_nxt(pass_nxt),
    .freq_ok (freq_ok)
  );

  run_detector #(
    .WORD_W   (WORD_W),
    .RUN_WORDS(RUN_WORDS)
  ) u_run (
    .clk       (clk),
    .rst_n     (rst_q),
    .word_valid(word_valid),
    .word      (word),
    .los_nxt   (los_nxt),
    .los       (sig_lost)
  );

  lock_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q),
    .force_ref_n(force_ref_n),
    .los_nxt    (los_nxt),
    .win_end    (win_end),
    .pass_nxt   (pass_nxt),
    .lock_data  (lock_data)
  );

  // R8: data is never tracked while signal is reported lost
  a_r8_los_blocks_data: assert property (@(posedge clk) disable iff (!rst_q)
    sig_lost |-> !lock_data);

endmodule

// File: tb/tb_rxsrc_lock_ctrl.sv
module tb_rxsrc_lock_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_LOG2   = 12;
  localparam int WIN        = 1 << WIN_LOG2;
  localparam int LOCK_PPM   = 1000;
  localparam int UNLOCK_PPM = 2000;
  localparam int WORD_W     = 10;
  localparam int RUN_WORDS  = 12;
  localparam int LT = (WIN * LOCK_PPM) / 1000000;    // 4
  localparam int UT = (WIN * UNLOCK_PPM) / 1000000;  // 8

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic word_valid = 1'b0;
  logic [WORD_W-1:0] word = '0;
  logic force_ref_n = 1'b1;
  logic lock_data, freq_ok, sig_lost;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxsrc_lock_ctrl #(
    .WIN_LOG2(WIN_LOG2), .LOCK_PPM(LOCK_PPM), .UNLOCK_PPM(UNLOCK_PPM),
    .WORD_W(WORD_W), .RUN_WORDS(RUN_WORDS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .word_valid(word_valid),
    .word(word), .force_ref_n(force_ref_n),
    .lock_data(lock_data), .freq_ok(freq_ok), .sig_lost(sig_lost)
  );

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  function automatic bit in_band(input int off, input bit was_ok);
    int m;
    m = (off < 0) ? -off : off;
    return was_ok ? (m <= UT) : (m <= LT);
  endfunction

  // expected state built from the requirements
  int m_ref, m_rec, m_run;
  bit m_pol, m_freq, m_lock, m_los;

  always @(posedge clk) begin
    if (!model_on) begin
      m_ref <= 0; m_rec <= 0; m_run <= 0; m_pol <= 0;
      m_freq <= 0; m_lock <= 0; m_los <= 0;
    end else begin
      int rec_s, run_n; bit pol_n, close, f_n, los_n, uni;
      rec_s = m_rec + (word_valid ? 1 : 0);
      close = ref_tick && (m_ref == WIN - 1);           // R2
      run_n = m_run; pol_n = m_pol;
      uni = (word == '0) || (word == '1);
      if (word_valid) begin
        if (!uni) run_n = 0;                            // R6
        else if (m_run != 0 && m_pol == word[0]) run_n = (m_run < RUN_WORDS) ? m_run + 1 : m_run;
        else begin run_n = 1; pol_n = word[0]; end      // R6 restart
      end
      los_n = (run_n >= RUN_WORDS);                     // R5
      f_n = m_freq;
      if (close) f_n = in_band(rec_s - WIN, m_freq);    // R3 R4
      if (!force_ref_n || los_n) m_lock <= 1'b0;        // R8
      else if (close) m_lock <= f_n;                    // R7
      m_freq <= f_n; m_los <= los_n; m_run <= run_n; m_pol <= pol_n;
      m_ref <= close ? 0 : (ref_tick ? m_ref + 1 : m_ref);
      m_rec <= close ? 0 : rec_s;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(freq_ok, m_freq, "R3/R4 model");
      chk(sig_lost, m_los, "R5/R6 model");
      chk(lock_data, m_lock, "R7/R8 model");
    end
  end

  // captured observations for directed checks
  bit cap_run_end, cap_after_run, cap_force, cap_mid;

  // one window: d extra (or missing) words, optional uniform run, force pulse, gap
  task automatic do_window(input int d, input int run_at, input int run_len,
                           input bit pol, input bit split, input int force_at,
                           input int gap_at, input bit rnd);
    int total, lead, miss, rl, rstart;
    bit rp;
    lead = (d > 0) ? d : 0;
    miss = (d < 0) ? -d : 0;
    total = lead + WIN;
    rl = 0; rstart = -1; rp = 0;
    for (int i = 0; i < total; i++) begin
      logic [WORD_W-1:0] w;
      int k;
      k = i - lead;
      ref_tick = (i >= lead);
      word_valid = !((k >= 0 && k < miss) || i == gap_at);
      w = WORD_W'($urandom);
      w[0] = ~w[1];
      if (run_len > 0 && i >= run_at && i < run_at + run_len)
        w = {WORD_W{pol ^ (split && (i - run_at) >= 6)}};
      if (rnd) begin
        if (rl == 0 && ($urandom % 200) == 0) begin
          rl = 5 + ($urandom % 10); rp = $urandom % 2;
        end
        if (rl > 0) begin w = {WORD_W{rp}}; rl--; end
        force_ref_n = !(($urandom % 1500) == 0);
      end else begin
        force_ref_n = !(i >= force_at && i < force_at + 5 && force_at >= 0);
      end
      word = w;
      @(negedge clk);
      if (i == run_at + run_len - 1) cap_run_end = sig_lost;
      if (i == run_at + run_len)     cap_after_run = sig_lost;
      if (i == force_at)             cap_force = lock_data;
      if (i == 1500)                 cap_mid = lock_data;
    end
    ref_tick = 1'b0; word_valid = 1'b0; force_ref_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(lock_data, 1'b0, "R1 lock_data");
    chk(freq_ok, 1'b0, "R1 freq_ok");
    chk(sig_lost, 1'b0, "R1 sig_lost");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(lock_data, 1'b0, "R1 lock_data after release");
    model_on = 1'b1;
    @(negedge clk);

    do_window(0, -1, 0, 0, 0, -1, -1, 0);
    chk(freq_ok, 1'b1, "R2 R3 zero offset locks");
    chk(lock_data, 1'b1, "R7 data selected at close");

    do_window(6, -1, 0, 0, 0, -1, -1, 0);
    chk(freq_ok, 1'b1, "R4 offset 6 holds lock");

    do_window(9, -1, 0, 0, 0, -1, -1, 0);
    chk(freq_ok, 1'b0, "R4 offset 9 unlocks");
    chk(lock_data, 1'b0, "R8 failed window drops data");

    do_window(6, -1, 0, 0, 0, -1, -1, 0);
    chk(freq_ok, 1'b0, "R3 offset 6 cannot relock");

    do_window(-3, -1, 0, 0, 0, -1, -1, 0);
    chk(freq_ok, 1'b1, "R3 offset -3 relocks");

    do_window(0, -1, 0, 0, 0, 1000, -1, 0);
    chk(cap_force, 1'b0, "R8 force drops data");
    chk(cap_mid, 1'b0, "R7 no relock before close");
    chk(lock_data, 1'b1, "R7 relock at close");

    do_window(0, 200, RUN_WORDS - 1, 0, 0, -1, -1, 0);
    chk(cap_run_end, 1'b0, "R5 11 zero words no loss");

    do_window(0, 200, RUN_WORDS, 1, 0, -1, -1, 0);
    chk(cap_run_end, 1'b1, "R5 12 one words loss");
    chk(cap_after_run, 1'b0, "R6 mixed word clears");
    chk(cap_mid, 1'b0, "R8 loss drops data");
    chk(lock_data, 1'b1, "R7 relock after loss");

    do_window(0, 200, RUN_WORDS + 2, 0, 0, -1, 205, 0);
    chk(cap_run_end, 1'b1, "R6 invalid cycle does not break run");

    do_window(0, 200, RUN_WORDS, 0, 1, -1, -1, 0);
    chk(cap_run_end, 1'b0, "R6 polarity change restarts run");

    for (int n = 0; n < 14; n++) begin
      int dd;
      dd = int'($urandom % 25) - 12;
      do_window(dd, -1, 0, 0, 0, -1, -1, 1);
      chk(freq_ok, m_freq, "R3/R4 random window");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule